// File: doc/BRIEF.md
# Convolutional Symbol Interleaver

This block spreads a stream of 8-bit symbols over time so that a run of corrupted symbols on the channel ends up scattered after the matching reverse operation. It holds `NUM_BRANCH` delay lines. The delay of each line grows linearly with its index, in steps of `BASE_DELAY` symbols. A commutator hands each accepted symbol to the next line in cyclic order. The output is taken from the same line that the symbol entered. Every line is a circular buffer that advances only when the commutator visits it. The total storage is therefore about half of a rectangular array with the same spreading, and the average delay is about half as long.

The parameter `DEINTERLEAVE` builds the receive side. In that mode the delay profile is reversed, so the line with the highest index has zero delay. An interleaver followed by a deinterleaver with the same parameters returns the original stream after a fixed latency of `(NUM_BRANCH-1)*NUM_BRANCH*BASE_DELAY` symbols. Symbols move only on the `valid_i` strobe. Cycles in which the strobe is low have no effect on the schedule.

Top module: `conv_interleaver`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `data_o` is 0.
- R2: The commutator starts on branch 0 after reset. The k-th accepted symbol after reset (k counted from 0) goes to branch k mod `NUM_BRANCH`. A new reset sends the commutator back to branch 0.
- R3: With `DEINTERLEAVE`=0, the output produced for accepted symbol n is input symbol n - j*`BASE_DELAY`*`NUM_BRANCH`, where j = n mod `NUM_BRANCH`. It appears on `data_o` one clock after the strobe that accepted symbol n.
- R4: With `DEINTERLEAVE`=1, the output produced for accepted symbol n is input symbol n - (`NUM_BRANCH`-1-j)*`BASE_DELAY`*`NUM_BRANCH`, where j = n mod `NUM_BRANCH`. The timing is the same as in R3.
- R5: If the source index given in R3 or R4 is negative, the output symbol is 0.
- R6: The branch with zero delay passes through the symbol of the same strobe. This is branch 0 in interleave mode and branch `NUM_BRANCH`-1 in deinterleave mode.
- R7: `valid_o` equals `valid_i` delayed by one clock. `data_o` keeps its value while `valid_o` is low. Each accepted symbol produces exactly one output.
- R8: Clock cycles with `valid_i` low do not advance the commutator or any delay line. The output sequence is the same with or without such gaps.
- R9: An interleaver feeding a deinterleaver with the same parameters returns input symbol n as the deinterleaver's output n + (`NUM_BRANCH`-1)*`NUM_BRANCH`*`BASE_DELAY`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input symbol strobe |
| data_i | input | DATA_W | Input symbol |
| valid_o | output | 1 | Output symbol strobe, one clock after `valid_i` |
| data_o | output | DATA_W | Output symbol |

## Verification
A commutator that skips a branch or steps on an idle cycle shows up on the next accepted symbol. From then on every output comes from the wrong line, including the pass-through line, so the error is visible within one revolution. A wrong read or write pointer inside branch j stays hidden while that line still returns reset zeros. It only shows once the line has filled, j*`BASE_DELAY`*`NUM_BRANCH` symbols after reset. For that reason the streams run well past the longest fill time. The chained pair makes the same point end to end: wrong data reappears exactly one full latency later.

// File: rtl/conv_ilv_pkg.sv
package conv_ilv_pkg;

  // depth of one branch in commutator visits
  function automatic int branch_depth(int idx, int branches, int base, bit deint);
    return deint ? (branches - 1 - idx) * base : idx * base;
  endfunction

  // index of the branch that carries no delay
  function automatic int zero_branch(int branches, bit deint);
    return deint ? branches - 1 : 0;
  endfunction

endpackage

// File: rtl/conv_ilv_commutator.sv
module conv_ilv_commutator #(
  parameter int NUM_BRANCH = 12,
  localparam int SEL_W = (NUM_BRANCH > 1) ? $clog2(NUM_BRANCH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [SEL_W-1:0] sel_o
);

  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_BRANCH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o <= '0;
    end else if (adv_i) begin
      sel_o <= (sel_o == LAST_SEL) ? '0 : sel_o + 1'b1;
    end
  end

endmodule

// File: rtl/conv_ilv_branch.sv
module conv_ilv_branch #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);

  if (DEPTH == 1) begin : g_single
    logic [DATA_W-1:0] slot_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else if (en_i) begin
        slot_q <= wr_data_i;
      end
    end

    assign rd_data_o = slot_q;
  end else begin : g_ring
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DEPTH-1:0][DATA_W-1:0] mem_q;
    logic [PTR_W-1:0]             ptr_q;

    // the oldest entry sits at the pointer and is replaced when the branch is visited
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q <= '0;
        ptr_q <= '0;
      end else if (en_i) begin
        mem_q[ptr_q] <= wr_data_i;
        ptr_q        <= (ptr_q == LAST_PTR) ? '0 : ptr_q + 1'b1;
      end
    end

    assign rd_data_o = mem_q[ptr_q];
  end

endmodule

// File: rtl/conv_ilv_out.sv
module conv_ilv_out #(
  parameter int NUM_BRANCH = 12,
  parameter int DATA_W     = 8,
  localparam int SEL_W = (NUM_BRANCH > 1) ? $clog2(NUM_BRANCH) : 1
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 valid_i,
  input  logic [SEL_W-1:0]                     sel_i,
  input  logic [NUM_BRANCH-1:0][DATA_W-1:0]    tap_i,
  output logic                                 valid_o,
  output logic [DATA_W-1:0]                    data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o <= tap_i[sel_i];
      end
    end
  end

endmodule

// File: rtl/conv_interleaver.sv
module conv_interleaver
  import conv_ilv_pkg::*;
#(
  parameter int NUM_BRANCH   = 12,
  parameter int BASE_DELAY   = 17,
  parameter int DATA_W       = 8,
  parameter bit DEINTERLEAVE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int SEL_W = (NUM_BRANCH > 1) ? $clog2(NUM_BRANCH) : 1;

  logic [SEL_W-1:0]                  branch_sel;
  logic [NUM_BRANCH-1:0][DATA_W-1:0] tap_data;

  conv_ilv_commutator #(
    .NUM_BRANCH(NUM_BRANCH)
  ) i_commutator (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (valid_i),
    .sel_o (branch_sel)
  );

  for (genvar j = 0; j < NUM_BRANCH; j++) begin : g_branch
    localparam int DEPTH = branch_depth(j, NUM_BRANCH, BASE_DELAY, DEINTERLEAVE);

    if (DEPTH == 0) begin : g_pass
      assign tap_data[j] = data_i;
    end else begin : g_line
      logic visit;
      assign visit = valid_i && (branch_sel == SEL_W'(j));

      conv_ilv_branch #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
      ) i_line (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (visit),
        .wr_data_i(data_i),
        .rd_data_o(tap_data[j])
      );
    end
  end

  conv_ilv_out #(
    .NUM_BRANCH(NUM_BRANCH),
    .DATA_W    (DATA_W)
  ) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .sel_i  (branch_sel),
    .tap_i  (tap_data),
    .valid_o(valid_o),
    .data_o (data_o)
  );

endmodule

// File: rtl/conv_interleaver_chk.sv
module conv_interleaver_chk
  import conv_ilv_pkg::*;
#(
  parameter int NUM_BRANCH   = 12,
  parameter int DATA_W       = 8,
  parameter bit DEINTERLEAVE = 1'b0,
  localparam int SEL_W = (NUM_BRANCH > 1) ? $clog2(NUM_BRANCH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic [SEL_W-1:0]  sel_i
);

  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_BRANCH - 1);
  localparam logic [SEL_W-1:0] ZERO_SEL = SEL_W'(zero_branch(NUM_BRANCH, DEINTERLEAVE));

  AST_STROBE_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o)); // R7
  AST_SEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i <= LAST_SEL); // R2
  AST_SEL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_i == LAST_SEL) |=> sel_i == '0); // R2
  AST_SEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_i != LAST_SEL) |=> sel_i == SEL_W'($past(sel_i) + 1'b1)); // R2
  AST_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sel_i)); // R8
  AST_ZERO_TAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_i == ZERO_SEL) |=> data_o == $past(data_i)); // R6

endmodule

bind conv_interleaver conv_interleaver_chk #(
  .NUM_BRANCH  (NUM_BRANCH),
  .DATA_W      (DATA_W),
  .DEINTERLEAVE(DEINTERLEAVE)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .data_i (data_i),
  .valid_o(valid_o),
  .data_o (data_o),
  .sel_i  (branch_sel)
);

// File: tb/test_conv_interleaver.sv
module test_conv_interleaver;

  localparam int NB  = 5;
  localparam int BD  = 3;
  localparam int DW  = 8;
  localparam int LAT = (NB - 1) * NB * BD;
  localparam int HIST = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vin = 1'b0;
  logic [DW-1:0] din = '0;
  logic          vmid, vout;
  logic [DW-1:0] dmid, dout;

  always #4 clk = ~clk;  // 125 MHz

  conv_interleaver #(
    .NUM_BRANCH(NB), .BASE_DELAY(BD), .DATA_W(DW), .DEINTERLEAVE(1'b0)
  ) i_conv_interleaver (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .data_i(din),
    .valid_o(vmid), .data_o(dmid)
  );

  conv_interleaver #(
    .NUM_BRANCH(NB), .BASE_DELAY(BD), .DATA_W(DW), .DEINTERLEAVE(1'b1)
  ) i_conv_deinterleaver (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vmid), .data_i(dmid),
    .valid_o(vout), .data_o(dout)
  );

  int checks = 0;
  int fails  = 0;
  int n_sym  = 0;
  bit gapped = 1'b0;
  bit after_rst = 1'b0;
  logic [DW-1:0] in_hist  [HIST];
  logic [DW-1:0] ilv_hist [HIST];
  logic [DW-1:0] q1_d[$];
  string         q1_t[$];
  logic [DW-1:0] q2_d[$];
  string         q2_t[$];
  logic [DW-1:0] last1 = '0;
  logic [DW-1:0] last2 = '0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // driver: applies one symbol and records what both stages must emit for it
  task automatic send(input logic [DW-1:0] d, input int gap);
    int j, src, jd, src2;
    logic [DW-1:0] e1, e2;
    string t1, t2;
    @(negedge clk);
    vin = 1'b1;
    din = d;
    in_hist[n_sym] = d;
    j   = n_sym % NB;
    src = n_sym - j * BD * NB;
    e1  = (src >= 0) ? in_hist[src] : '0;          // R3 / R5
    ilv_hist[n_sym] = e1;
    if (after_rst && n_sym < NB) t1 = "R2";
    else if (j == 0)              t1 = "R6";
    else if (src < 0)             t1 = "R5";
    else if (gapped)              t1 = "R8";
    else                          t1 = "R3";
    jd   = NB - 1 - j;
    src2 = n_sym - jd * BD * NB;
    if (n_sym >= LAT) begin
      e2 = in_hist[n_sym - LAT];                    // R9
      t2 = "R9";
    end else begin
      e2 = (src2 >= 0) ? ilv_hist[src2] : '0;        // R4 / R5
      t2 = (src2 >= 0) ? "R4" : "R5";
    end
    q1_d.push_back(e1);
    q1_t.push_back(t1);
    q2_d.push_back(e2);
    q2_t.push_back(t2);
    n_sym++;
    repeat (gap) begin
      @(negedge clk);
      vin = 1'b0;
    end
  endtask

  task automatic idle(input int cycles);
    @(negedge clk);
    vin = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    vin   = 1'b0;
    #1;
    chk("R1 valid_o intl", int'(vmid), 0);
    chk("R1 data_o intl", int'(dmid), 0);
    chk("R1 valid_o deint", int'(vout), 0);
    chk("R1 data_o deint", int'(dout), 0);
    q1_d.delete(); q1_t.delete();
    q2_d.delete(); q2_t.delete();
    n_sym = 0;
    last1 = '0;
    last2 = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    after_rst = 1'b1;
  endtask

  // monitors: pop expected items as outputs appear, away from the clock edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (vmid) begin
        if (q1_d.size() == 0) begin
          chk("R7 unexpected intl output", 1, 0);
        end else begin
          chk({q1_t.pop_front(), " intl"}, int'(dmid), int'(q1_d.pop_front()));
        end
        last1 = dmid;
      end else begin
        chk("R7 intl hold", int'(dmid), int'(last1));
      end
      if (vout) begin
        if (q2_d.size() == 0) begin
          chk("R7 unexpected deint output", 1, 0);
        end else begin
          chk({q2_t.pop_front(), " deint"}, int'(dout), int'(q2_d.pop_front()));
        end
        last2 = dout;
      end else begin
        chk("R7 deint hold", int'(dout), int'(last2));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    #3;
    chk("R1 valid_o intl", int'(vmid), 0);
    chk("R1 data_o intl", int'(dmid), 0);
    chk("R1 valid_o deint", int'(vout), 0);
    chk("R1 data_o deint", int'(dout), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // back-to-back counting pattern
    for (int k = 0; k < 120; k++) send(DW'(k + 1), 0);
    idle(4);

    // R2: reset mid-stream, commutator and lines restart
    do_reset();
    gapped = 1'b1;  // R8: irregular idle cycles between strobes
    for (int k = 0; k < 150; k++) send(DW'(k * 37 + 11), k % 3);
    gapped = 1'b0;
    after_rst = 1'b0;

    // saturating patterns in blocks
    for (int k = 0; k < 80; k++) send(((k / 7) % 2 == 0) ? 8'hFF : 8'h00, 0);
    idle(4);

    chk("R7 intl outputs outstanding", q1_d.size(), 0);
    chk("R7 deint outputs outstanding", q2_d.size(), 0);
    summary();
    $finish;
  end

endmodule